// File: doc/BRIEF.md
# Serial Peripheral Master with Programmable Framing Delays

This block runs a serial peripheral bus as the master. A host presents a word of 8 to 16 bits, a clock polarity and phase, one of four peripheral selects, a clock divider and two delay values. It then raises a one-cycle start request. The block pulls the chosen active-low select low and waits the programmed lead time. It then toggles the serial clock twice per bit, shifting data out most significant bit first on `mosi` while it collects bits from `miso`. After the last bit it releases the select and pulses `done`. It stays busy for a programmed gap before it accepts another start.

Every setting is captured on the cycle a start is accepted, so the host may change its inputs during a transfer. A start that arrives while `busy` is high is ignored. Out-of-range settings are clamped: length to 8..16, half-period to at least 2 system clocks, lead to at least 2, gap to at least 6.

The sequencer has four states. IDLE waits for start (transition IDLE→LEAD on an accepted start). LEAD holds the select low with the clock at its idle level (LEAD→SHIFT on the first clock edge). SHIFT produces the clock edges (SHIFT→GAP when the select is released, one half-period after the final edge). GAP holds everything quiet (GAP→IDLE when the gap count expires).

Top module: `spi_xfer_master`

## Requirements
- R1: Out of reset and whenever the block is idle: all `cs_n` are 1, `busy`=0, `done`=0, `mosi`=0, and `sclk` equals the `cpol` input registered one cycle earlier (0 while reset is held). `rx_data` resets to 0.
- R2: A start sampled while idle drives `cs_n[cs_sel]` low (bit index = `cs_sel`, only that bit) and `busy` high on the next cycle. At most one select is low at any time.
- R3: The first serial clock edge comes exactly max(`lead_dly`,2) system cycles after the select goes low.
- R4: Serial clock edges are spaced max(`half_div`,2) system cycles apart. A transfer has exactly 2×length edges and ends at the idle level `cpol`. The clock does not move while busy with no select low.
- R5: The effective length is `xfer_len` clamped to the range 8..16.
- R6: Data leaves MSB first. With `cpha`=0 the first bit appears on `mosi` when the select falls and each further bit follows a trailing (return-to-idle) edge. With `cpha`=1 each bit follows a leading (away-from-idle) edge.
- R7: `miso` is sampled on the edges that do not launch data: leading edges for `cpha`=0, trailing edges for `cpha`=1. The received word is right-aligned in `rx_data` with unused upper bits 0.
- R8: One half-period after the final edge, the select is released, `mosi` returns to 0, `rx_data` updates, and `done` is high for exactly that one cycle.
- R9: After the select is released, `busy` stays high for max(`gap_dly`,6) cycles. A start held high is accepted on the first idle cycle after that.
- R10: A start while `busy` is high has no effect on the ports.
- R11: Changing `tx_data`, `xfer_len`, `cs_sel` or `half_div` during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transfer request, sampled while idle |
| xfer_len | input | 5 | Bits per transfer (clamped 8..16) |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: launch at select and on trailing edges; 1: launch on leading edges |
| cs_sel | input | 2 | Index of the select to drive |
| half_div | input | 8 | System cycles per serial clock half-period (min 2) |
| lead_dly | input | 13 | Cycles from select low to first clock edge (min 2) |
| gap_dly | input | 13 | Busy cycles after select release (min 6) |
| tx_data | input | 16 | Word to send, right-aligned |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | 4 | Active-low peripheral selects |
| rx_data | output | 16 | Last received word, right-aligned |
| busy | output | 1 | High from accepted start to end of gap |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong sequencer state or a miscounted delay shows at once as a select, clock or `busy` level that differs from the expected waveform in that same cycle. For this reason every port is compared against an independent expected timeline on every clock. A bad edge counter or a phase error in the shift path shows as a wrong `mosi` level within one half-period. The bench's peripheral model also catches it, because the word it assembles from `mosi` disagrees with `tx_data` at the `done` pulse. Errors on the receive side show only at `done`, as a wrong `rx_data` word, so each transfer uses a different peripheral word for every length and mode.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    // lower bounds applied to host settings
    localparam int unsigned MIN_LEN  = 8;
    localparam int unsigned MIN_HALF = 2;
    localparam int unsigned MIN_LEAD = 2;
    localparam int unsigned MIN_GAP  = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
    import spi_xfer_pkg::*;
#(
    parameter int LEN_W  = 5,
    parameter int SEL_W  = 2,
    parameter int DIV_W  = 8,
    parameter int LEAD_W = 13,
    parameter int GAP_W  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len_in,
    input  logic             cpol_in,
    input  logic             cpha_in,
    input  logic [SEL_W-1:0] sel_in,
    input  logic [DIV_W-1:0] half_in,
    input  logic [LEAD_W-1:0] lead_in,
    input  logic [GAP_W-1:0] gap_in,
    output logic             busy,
    output logic             done,
    output logic             sclk,
    output logic             cs_act,
    output logic [SEL_W-1:0] sel_q,
    output logic             cpha_q,
    output logic             load,
    output logic             edge_go,
    output logic             edge_lead,
    output logic             edge_last,
    output logic             finish
);

    localparam int EDGE_W = LEN_W + 1;
    localparam int CNT_A  = (DIV_W > LEAD_W) ? DIV_W : LEAD_W;
    localparam int CNT_W  = (CNT_A > GAP_W) ? CNT_A : GAP_W;

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [EDGE_W-1:0] ek_q;
    logic [LEN_W-1:0]  len_q;
    logic [DIV_W-1:0]  half_q;
    logic [GAP_W-1:0]  gap_q;
    logic              sclk_q, cs_q, done_q;

    logic              cnt_zero, all_edges;
    logic [EDGE_W-1:0] edge_total;

    assign edge_total = {len_q, 1'b0};
    assign cnt_zero   = (cnt_q == '0);
    assign all_edges  = (ek_q == edge_total);
    assign edge_lead  = ~ek_q[0];
    assign edge_last  = (ek_q == (edge_total - EDGE_W'(1)));

    assign load    = (state_q == ST_IDLE) && start;
    assign edge_go = cnt_zero && ((state_q == ST_LEAD) ||
                                  ((state_q == ST_SHIFT) && !all_edges));
    assign finish  = cnt_zero && (state_q == ST_SHIFT) && all_edges;

    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;
    assign sclk   = sclk_q;
    assign cs_act = cs_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)    state_d = ST_LEAD;
            ST_LEAD:  if (cnt_zero) state_d = ST_SHIFT;
            ST_SHIFT: if (finish)   state_d = ST_GAP;
            ST_GAP:   if (cnt_zero) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ek_q   <= '0;
            len_q  <= LEN_W'(MIN_LEN);
            half_q <= DIV_W'(MIN_HALF);
            gap_q  <= GAP_W'(MIN_GAP);
            sel_q  <= '0;
            cpha_q <= 1'b0;
            sclk_q <= 1'b0;
            cs_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    sclk_q <= cpol_in;
                    if (start) begin
                        len_q  <= len_in;
                        half_q <= half_in;
                        gap_q  <= gap_in;
                        sel_q  <= sel_in;
                        cpha_q <= cpha_in;
                        cnt_q  <= CNT_W'(lead_in) - CNT_W'(1);
                        ek_q   <= '0;
                        cs_q   <= 1'b1;
                    end
                end
                ST_LEAD: begin
                    if (cnt_zero) begin
                        sclk_q <= ~sclk_q;
                        ek_q   <= ek_q + EDGE_W'(1);
                        cnt_q  <= CNT_W'(half_q) - CNT_W'(1);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (cnt_zero) begin
                        if (all_edges) begin
                            cs_q   <= 1'b0;
                            done_q <= 1'b1;
                            cnt_q  <= CNT_W'(gap_q) - CNT_W'(1);
                        end else begin
                            sclk_q <= ~sclk_q;
                            ek_q   <= ek_q + EDGE_W'(1);
                            cnt_q  <= CNT_W'(half_q) - CNT_W'(1);
                        end
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                ST_GAP: begin
                    if (!cnt_zero) cnt_q <= cnt_q - CNT_W'(1);
                end
            endcase
        end
    end

endmodule

// File: rtl/spi_data_path.sv
module spi_data_path #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              cpha_in,
    input  logic              cpha_q,
    input  logic              edge_go,
    input  logic              edge_lead,
    input  logic              edge_last,
    input  logic              finish,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data
);

    logic [DATA_W-1:0] aligned, tx_sh, rx_sh, rx_q;
    logic              mosi_q, launch, sample;

    // left-justify the word so the first bit sits in the top position
    assign aligned = tx_data << (LEN_W'(DATA_W) - len_in);

    assign launch = edge_go && (cpha_q ? edge_lead : (!edge_lead && !edge_last));
    assign sample = edge_go && (edge_lead ^ cpha_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            rx_sh  <= '0;
            rx_q   <= '0;
            mosi_q <= 1'b0;
        end else if (load) begin
            rx_sh <= '0;
            if (cpha_in) begin
                mosi_q <= 1'b0;
                tx_sh  <= aligned;
            end else begin
                mosi_q <= aligned[DATA_W-1];
                tx_sh  <= aligned << 1;
            end
        end else if (finish) begin
            mosi_q <= 1'b0;
            rx_q   <= rx_sh;
        end else begin
            if (launch) begin
                mosi_q <= tx_sh[DATA_W-1];
                tx_sh  <= tx_sh << 1;
            end
            if (sample) rx_sh <= {rx_sh[DATA_W-2:0], miso};
        end
    end

    assign mosi    = mosi_q;
    assign rx_data = rx_q;

endmodule

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
    parameter int NCS   = 4,
    parameter int SEL_W = 2
) (
    input  logic             active,
    input  logic [SEL_W-1:0] sel,
    output logic [NCS-1:0]   cs_n
);

    for (genvar i = 0; i < NCS; i++) begin : g_sel
        assign cs_n[i] = !(active && (sel == SEL_W'(i)));
    end

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NCS    = 4,
    parameter int DIV_W  = 8,
    parameter int LEAD_W = 13,
    parameter int GAP_W  = 13,
    localparam int LEN_W = $clog2(DATA_W + 1),
    localparam int SEL_W = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [SEL_W-1:0]  cs_sel,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [LEAD_W-1:0] lead_dly,
    input  logic [GAP_W-1:0]  gap_dly,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [NCS-1:0]    cs_n,
    output logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output logic              done
);

    logic [LEN_W-1:0]  eff_len;
    logic [DIV_W-1:0]  eff_half;
    logic [LEAD_W-1:0] eff_lead;
    logic [GAP_W-1:0]  eff_gap;

    // clamp host settings to their legal ranges
    always_comb begin
        if (xfer_len < LEN_W'(MIN_LEN))   eff_len = LEN_W'(MIN_LEN);
        else if (xfer_len > LEN_W'(DATA_W)) eff_len = LEN_W'(DATA_W);
        else                                eff_len = xfer_len;
        eff_half = (half_div < DIV_W'(MIN_HALF))  ? DIV_W'(MIN_HALF)  : half_div;
        eff_lead = (lead_dly < LEAD_W'(MIN_LEAD)) ? LEAD_W'(MIN_LEAD) : lead_dly;
        eff_gap  = (gap_dly  < GAP_W'(MIN_GAP))   ? GAP_W'(MIN_GAP)   : gap_dly;
    end

    logic             cs_act, cpha_q, load, edge_go, edge_lead, edge_last, finish;
    logic [SEL_W-1:0] sel_q;

    spi_seq_ctrl #(
        .LEN_W (LEN_W),
        .SEL_W (SEL_W),
        .DIV_W (DIV_W),
        .LEAD_W(LEAD_W),
        .GAP_W (GAP_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .len_in   (eff_len),
        .cpol_in  (cpol),
        .cpha_in  (cpha),
        .sel_in   (cs_sel),
        .half_in  (eff_half),
        .lead_in  (eff_lead),
        .gap_in   (eff_gap),
        .busy     (busy),
        .done     (done),
        .sclk     (sclk),
        .cs_act   (cs_act),
        .sel_q    (sel_q),
        .cpha_q   (cpha_q),
        .load     (load),
        .edge_go  (edge_go),
        .edge_lead(edge_lead),
        .edge_last(edge_last),
        .finish   (finish)
    );

    spi_data_path #(
        .DATA_W(DATA_W),
        .LEN_W (LEN_W)
    ) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .tx_data  (tx_data),
        .len_in   (eff_len),
        .cpha_in  (cpha),
        .cpha_q   (cpha_q),
        .edge_go  (edge_go),
        .edge_lead(edge_lead),
        .edge_last(edge_last),
        .finish   (finish),
        .miso     (miso),
        .mosi     (mosi),
        .rx_data  (rx_data)
    );

    spi_cs_decode #(
        .NCS  (NCS),
        .SEL_W(SEL_W)
    ) u_cs (
        .active(cs_act),
        .sel   (sel_q),
        .cs_n  (cs_n)
    );

endmodule

// File: rtl/spi_xfer_chk.sv
module spi_xfer_chk #(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic           sclk,
    input logic [NCS-1:0] cs_n
);

    // R1
    idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&cs_n));

    // R2
    one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R2
    cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(&cs_n) |-> busy);

    // R4
    gap_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (&cs_n)) |-> $stable(sclk));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&cs_n) |-> done);

    // R9
    gap_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> busy);

endmodule

bind spi_xfer_master spi_xfer_chk #(.NCS(NCS)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .busy (busy),
    .done (done),
    .sclk (sclk),
    .cs_n (cs_n)
);

// File: tb/sim_spi_xfer_master.sv
module sim_spi_xfer_master;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  xfer_len = 5'd8;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic [1:0]  cs_sel = 2'd0;
    logic [7:0]  half_div = 8'd2;
    logic [12:0] lead_dly = 13'd2;
    logic [12:0] gap_dly = 13'd6;
    logic [15:0] tx_data = 16'h0;
    logic        miso = 1'b0;
    wire         sclk, mosi, busy, done;
    wire [3:0]   cs_n;
    wire [15:0]  rx_data;

    spi_xfer_master u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
        .cpol(cpol), .cpha(cpha), .cs_sel(cs_sel), .half_div(half_div),
        .lead_dly(lead_dly), .gap_dly(gap_dly), .tx_data(tx_data),
        .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .rx_data(rx_data), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0;
    int bad = 0;
    string cur_tag = "R1";

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h (test %s)", tag, what, act, exp, cur_tag);
        end
    endtask

    function automatic int clampi(int v, int lo, int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // ---------------- behavioural peripheral ----------------
    logic [15:0] slv_word = 16'h0;
    logic [15:0] sl_word = 16'h0;
    logic [15:0] sl_got = 16'h0;
    int          sl_len = 8;
    int          sl_idx = 0;
    bit          sl_cpol = 0;
    bit          sl_cpha = 0;
    wire         cs_all = &cs_n;

    always @(negedge cs_all) begin
        sl_idx = 0;
        sl_got = 16'h0;
        if (!sl_cpha) begin
            miso   = sl_word[sl_len-1];
            sl_idx = 1;
        end
    end

    always @(sclk) begin
        if (cs_all === 1'b0) begin
            bit lead_e;
            lead_e = (sclk != sl_cpol);
            if (lead_e ^ sl_cpha) begin
                sl_got = {sl_got[14:0], mosi};
            end else if (sl_idx < sl_len) begin
                miso   = sl_word[sl_len-1-sl_idx];
                sl_idx = sl_idx + 1;
            end
        end
    end

    // ---------------- cycle reference model ----------------
    typedef struct packed {
        logic [3:0] cs;
        logic       sclk;
        logic       mosi;
        logic       busy;
        logic       done;
    } exp_t;

    exp_t        exp_q[$];
    logic        idle_cpol = 1'b0;
    logic        last_busy = 1'b0;
    bit          armed = 0;
    logic [15:0] exp_rx = 16'h0;
    logic [15:0] exp_tx = 16'h0;

    function automatic void build();
        int L, H, D, G, n;
        logic [15:0] mask;
        L = clampi(int'(xfer_len), 8, 16);   // R5
        H = clampi(int'(half_div), 2, 1000);
        D = clampi(int'(lead_dly), 2, 100000);
        G = clampi(int'(gap_dly), 6, 100000);
        mask = 16'((32'h1 << L) - 1);
        exp_rx = slv_word & mask;
        exp_tx = tx_data & mask;
        sl_word = slv_word;
        sl_len = L;
        sl_cpol = cpol;
        sl_cpha = cpha;
        n = D + 2 * L * H + G;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            int m, b;
            e.busy = 1'b1;
            e.done = 1'b0;
            e.cs   = (i < D + 2 * L * H) ? ~(4'b0001 << cs_sel) : 4'hF;
            e.sclk = cpol;
            e.mosi = 1'b0;
            if (i < D) begin
                e.mosi = cpha ? 1'b0 : tx_data[L-1];
            end else if (i < D + 2 * L * H) begin
                m = (i - D) / H;
                e.sclk = cpol ^ ((m + 1) % 2 == 1);
                b = cpha ? (m / 2) : clampi((m + 1) / 2, 0, L - 1);
                e.mosi = tx_data[L-1-b];
            end else if (i == D + 2 * L * H) begin
                e.done = 1'b1;
            end
            exp_q.push_back(e);
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            last_busy = 1'b0;
            armed = 0;
        end else begin
            if (exp_q.size() == 0 && !last_busy && start) build();
            idle_cpol = cpol;
            armed = 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && armed) begin
            exp_t e;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
            end else begin
                e.cs = 4'hF; e.sclk = idle_cpol; e.mosi = 1'b0;
                e.busy = 1'b0; e.done = 1'b0;
            end
            chk("R2", "cs_n", 32'(cs_n), 32'(e.cs));
            chk("R4", "sclk", 32'(sclk), 32'(e.sclk));
            chk("R6", "mosi", 32'(mosi), 32'(e.mosi));
            chk("R9", "busy", 32'(busy), 32'(e.busy));
            chk("R8", "done", 32'(done), 32'(e.done));
            last_busy = e.busy;
            if (e.done) begin
                chk("R7", "rx_data", 32'(rx_data), 32'(exp_rx));
                chk("R6", "word seen by peripheral", 32'(sl_got), 32'(exp_tx));
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic setup(int l, bit p, bit ph, int s, int h, int ld, int gp,
                         logic [15:0] tx, logic [15:0] sw, string tag);
        @(negedge clk);
        cur_tag  = tag;
        xfer_len = 5'(l);
        cpol     = p;
        cpha     = ph;
        cs_sel   = 2'(s);
        half_div = 8'(h);
        lead_dly = 13'(ld);
        gap_dly  = 13'(gp);
        tx_data  = tx;
        slv_word = sw;
        @(negedge clk);
    endtask

    task automatic run_xfer(int l, bit p, bit ph, int s, int h, int ld, int gp,
                            logic [15:0] tx, logic [15:0] sw, string tag);
        setup(l, p, ph, s, h, ld, gp, tx, sw, tag);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "cs_n in reset", 32'(cs_n), 32'hF);
        chk("R1", "busy in reset", 32'(busy), 32'h0);
        chk("R1", "done in reset", 32'(done), 32'h0);
        chk("R1", "mosi in reset", 32'(mosi), 32'h0);
        chk("R1", "sclk in reset", 32'(sclk), 32'h0);
        chk("R1", "rx_data in reset", 32'(rx_data), 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R5 R6 R7: every length, modes rotating, varied delays
        for (int l = 8; l <= 16; l++) begin
            run_xfer(l, l[0], l[1], l % 4, 2 + (l % 3), 2 + l, 6 + (l % 4),
                     16'hA5C3 ^ 16'(l * 16'h1111), 16'h3C96 ^ 16'(l * 16'h0707), "R5");
        end

        // R6 R7: all four polarity/phase modes at one length
        for (int m = 0; m < 4; m++) begin
            run_xfer(12, m[1], m[0], m, 3, 5, 7, 16'h0B6D, 16'h0E29 ^ 16'(m), "R6");
        end

        // R3 R4 R9: minimum clamps (0 -> 2, 1 -> 2, 0 -> 6)
        run_xfer(10, 1'b0, 1'b0, 1, 1, 0, 0, 16'h02D5, 16'h0133, "R3");
        run_xfer(9, 1'b1, 1'b1, 3, 0, 1, 3, 16'h01A7, 16'h00F1, "R4");

        // R3: long lead and long gap
        run_xfer(8, 1'b1, 1'b1, 2, 4, 300, 40, 16'h00C9, 16'h0057, "R3");

        // R5: lengths out of range
        run_xfer(3, 1'b0, 1'b1, 0, 2, 3, 6, 16'hFF3A, 16'h00A6, "R5");
        run_xfer(31, 1'b1, 1'b0, 1, 2, 3, 6, 16'h8E17, 16'hC4B2, "R5");

        // R10 R11: start and setting changes while busy
        setup(11, 1'b0, 1'b1, 2, 3, 4, 8, 16'h05B9, 16'h0362, "R10");
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        cur_tag  = "R11";
        start    = 1'b1;
        tx_data  = 16'hFFFF;
        xfer_len = 5'd16;
        cs_sel   = 2'd0;
        half_div = 8'd7;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);

        // R9: start held high, accepted right after the gap
        setup(8, 1'b0, 1'b0, 3, 2, 2, 6, 16'h00E4, 16'h009B, "R9");
        start = 1'b1;
        @(negedge clk);
        while (busy) @(negedge clk);
        tx_data  = 16'h0071;
        slv_word = 16'h00CE;
        @(negedge clk);
        chk("R9", "busy after back-to-back start", 32'(busy), 32'h1);
        start = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule